// File: doc/BRIEF.md
# Synchronous Burst SRAM Read/Deselect Pipeline

This block is a behavioural model of a synchronous SRAM core whose bus timing can be chosen at run time. Each clock edge captures one command in an input register. The command is one of three kinds: a read, a write, or a deselect (chip select low). Every word holds four 9-bit byte lanes. A write stores either the lanes picked by a byte-select mask or, under global write, the whole word.

Read data reaches the bus in one of two ways. In flow-through mode it goes around the output register. In pipeline mode it passes through that register and so arrives one clock later. A second mode input sets when a deselect releases the bus. With dual-cycle deselect, the release has the same latency as read data. With single-cycle deselect, it comes one stage earlier. An active-high output enable and a sleep input gate the bus at once, with no clock needed. Sleep also blocks new commands, and the memory keeps its contents. The intended default is pipeline mode with single-cycle deselect (`pipe_mode`=1, `dcd_mode`=0). The mode inputs are meant to change only while the bus is idle.

Top module: `sbsram_core`

## Requirements
- R1: While reset is asserted, and after it is released until a read reaches the output, `dq_drive` is 0 and `dq_o` is 0.
- R2: A selected command with `gwr`=1 writes all four 9-bit lanes of the addressed word, whatever the values of `bwe` and `bsel`.
- R3: With `gwr`=0 and `bwe`=1, lane i (bits 9i+8..9i) is written only when `bsel[i]`=1. A selected command with `gwr`=0 and either `bwe`=0 or `bsel`=0 is a read.
- R4: In flow-through mode (`pipe_mode`=0), a read captured at edge n drives its word on `dq_o` during the cycle that follows edge n.
- R5: In pipeline mode (`pipe_mode`=1), a read captured at edge n drives its word during the cycle that follows edge n+1.
- R6: In pipeline mode with `dcd_mode`=1, a deselect captured at edge n releases the bus after edge n+1. A read captured at edge n-1 is still shown in full.
- R7: In pipeline mode with `dcd_mode`=0, a deselect captured at edge n releases the bus right after edge n. This cuts off the data of a read captured at edge n-1.
- R8: In flow-through mode, a deselect captured at edge n releases the bus right after edge n, whatever the value of `dcd_mode`.
- R9: When `out_en` is 0, `dq_drive` and `dq_o` go to 0 at once, without waiting for a clock edge. They recover when `out_en` returns to 1.
- R10: While `sleep` is 1, the bus is released at once and each edge captures a deselect, so no write takes place. Memory contents are kept, and the first edge after `sleep` falls captures a command again.
- R11: A write never drives the bus. A read captured on the edge after a write to the same address returns the newly written lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_mode | input | 1 | 1: registered read output, 0: flow-through |
| dcd_mode | input | 1 | 1: dual-cycle deselect, 0: single-cycle deselect |
| out_en | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous sleep: releases the bus and blocks commands |
| cs | input | 1 | Chip select; 0 captures a deselect |
| gwr | input | 1 | Global write of all lanes |
| bwe | input | 1 | Byte-write enable, qualified by `bsel` |
| bsel | input | 4 | Per-lane write select |
| addr | input | 8 | Word address |
| wdata | input | 36 | Write data, captured with the command |
| dq_o | output | 36 | Read data, 0 when the bus is not driven |
| dq_drive | output | 1 | 1 while the core drives the data bus |

## Verification
A wrong read-stage or drive state shows up at the ports on the very next sampled cycle. The bus comes on or goes off one cycle early or late, or a cut-off read from single-cycle deselect lingers. A wrong lane mask or a lost write stays hidden until that address is read again, so the bench reads every location back after each write pattern. It also compares every cycle under all four mode pairs. The output enable and sleep gates are checked part-way through a cycle, which exposes any dependence on a clock edge at once.

// File: rtl/sbsram_pkg.sv
// Shared command encoding for the synchronous SRAM core.
// Assumes nothing beyond a single command per clock edge.
package sbsram_pkg;

    typedef enum logic [1:0] {
        OP_DESEL = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } sram_op_t;

endpackage

// File: rtl/sbsram_cmd_reg.sv
// Input stage: decodes chip select and write controls into one command
// and registers it with address, lane mask and write data.
// Assumes sleep is sampled at the edge; a sleeping edge captures a deselect.
module sbsram_cmd_reg
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sleep,
    input  logic                      cs,
    input  logic                      gwr,
    input  logic                      bwe,
    input  logic [LANES-1:0]          bsel,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output sram_op_t                  op_q,
    output logic [ADDR_W-1:0]         addr_q,
    output logic [LANES-1:0]          mask_q,
    output logic [LANES*LANE_W-1:0]   wdata_q
);

    localparam int DATA_W = LANES * LANE_W;

    sram_op_t         op_d;
    logic [LANES-1:0] mask_d;

    // Classify the incoming command and form its lane mask.
    always_comb begin
        mask_d = gwr ? {LANES{1'b1}} : bsel;
        if (!cs) begin
            op_d = OP_DESEL;
        end else if (gwr || (bwe && (|bsel))) begin
            op_d = OP_WRITE;
        end else begin
            op_d = OP_READ;
        end
    end

    // Capture the command; reset and sleep both force a deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_DESEL;
            addr_q  <= '0;
            mask_q  <= '0;
            wdata_q <= '0;
        end else if (sleep) begin
            op_q    <= OP_DESEL;
        end else begin
            op_q    <= op_d;
            addr_q  <= addr;
            mask_q  <= mask_d;
            wdata_q <= wdata[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/sbsram_array.sv
// Storage: one array per byte lane, written at the edge after capture,
// read combinationally at the captured address.
// Assumes the same address register feeds both read and write ports.
module sbsram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [LANES-1:0]          lane_mask,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        // Commit this lane when the pending write selects it.
        always_ff @(posedge clk) begin
            if (wr_en && lane_mask[g]) begin
                store[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = store[addr];
    end

endmodule

// File: rtl/sbsram_out_path.sv
// Output stage: optional data register, read/deselect drive timing and
// asynchronous gating by output enable and sleep.
// Assumes mode inputs change only while the bus is idle.
module sbsram_out_path
    import sbsram_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              dcd_mode,
    input  logic              out_en,
    input  logic              sleep,
    input  sram_op_t          op_q,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_drive
);

    logic              rd_q;
    logic [DATA_W-1:0] data_q;
    logic              drv_int;

    // Second stage: remember whether a read was captured, and its word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            data_q <= '0;
        end else begin
            rd_q   <= (op_q == OP_READ);
            data_q <= rd_data;
        end
    end

    // Pick the drive timing from the read path and deselect modes.
    always_comb begin
        if (!pipe_mode) begin
            drv_int = (op_q == OP_READ);
        end else if (dcd_mode) begin
            drv_int = rd_q;
        end else begin
            drv_int = rd_q && (op_q != OP_DESEL);
        end
    end

    // Gate the bus without a clock and zero the data when released.
    always_comb begin
        dq_drive = drv_int && out_en && !sleep;
        if (!dq_drive) begin
            dq_o = '0;
        end else if (pipe_mode) begin
            dq_o = data_q;
        end else begin
            dq_o = rd_data;
        end
    end

endmodule

// File: rtl/sbsram_core.sv
// Top of the synchronous SRAM core: input register, lane storage and
// output path with selectable read latency and deselect timing.
// Assumes one command per edge and static modes during traffic.
module sbsram_core
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pipe_mode,
    input  logic                      dcd_mode,
    input  logic                      out_en,
    input  logic                      sleep,
    input  logic                      cs,
    input  logic                      gwr,
    input  logic                      bwe,
    input  logic [LANES-1:0]          bsel,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   dq_o,
    output logic                      dq_drive
);

    localparam int DATA_W = LANES * LANE_W;

    sram_op_t          op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_data;

    sbsram_cmd_reg #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep   (sleep),
        .cs      (cs),
        .gwr     (gwr),
        .bwe     (bwe),
        .bsel    (bsel),
        .addr    (addr),
        .wdata   (wdata),
        .op_q    (op_q),
        .addr_q  (addr_q),
        .mask_q  (mask_q),
        .wdata_q (wdata_q)
    );

    sbsram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_mem (
        .clk       (clk),
        .wr_en     (op_q == OP_WRITE),
        .lane_mask (mask_q),
        .addr      (addr_q),
        .wdata     (wdata_q),
        .rd_data   (rd_data)
    );

    sbsram_out_path #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .dcd_mode  (dcd_mode),
        .out_en    (out_en),
        .sleep     (sleep),
        .op_q      (op_q),
        .rd_data   (rd_data),
        .dq_o      (dq_o),
        .dq_drive  (dq_drive)
    );

endmodule

// File: rtl/sbsram_core_chk.sv
// Port-level timing checks for sbsram_core, attached by bind.
// Assumes modes are held across the cycles each property spans.
module sbsram_core_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pipe_mode,
    input logic             dcd_mode,
    input logic             out_en,
    input logic             sleep,
    input logic             cs,
    input logic             gwr,
    input logic             bwe,
    input logic [LANES-1:0] bsel,
    input logic             dq_drive
);

    // Output enable low means the bus is released.
    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !dq_drive);

    // Sleep means the bus is released.
    assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_drive);

    // Pipeline, single-cycle deselect: off in the cycle after capture.
    assert_scd_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pipe_mode && !dcd_mode && !cs) && pipe_mode && !dcd_mode) |-> !dq_drive);

    // Pipeline, dual-cycle deselect: off one cycle later than capture.
    assert_dcd_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pipe_mode && dcd_mode && !cs, 2) && $past(pipe_mode && dcd_mode)
         && pipe_mode && dcd_mode) |-> !dq_drive);

    // Flow-through: deselect releases right after capture.
    assert_flow_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!pipe_mode && !cs) && !pipe_mode) |-> !dq_drive);

    // Flow-through: a captured write does not drive the bus.
    assert_write_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!pipe_mode && cs && (gwr || (bwe && (|bsel)))) && !pipe_mode) |-> !dq_drive);

endmodule

bind sbsram_core sbsram_core_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .dcd_mode  (dcd_mode),
    .out_en    (out_en),
    .sleep     (sleep),
    .cs        (cs),
    .gwr       (gwr),
    .bwe       (bwe),
    .bsel      (bsel),
    .dq_drive  (dq_drive)
);

// File: tb/sim_sbsram_core.sv
`timescale 1ns/1ps
// Bench for sbsram_core: a behavioural model (word array, last captured
// command, previous read flag) predicts the bus every cycle.
module sim_sbsram_core;

    localparam int AW = 8;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b1;
    logic          dcd_mode = 1'b0;
    logic          out_en = 1'b1;
    logic          sleep = 1'b0;
    logic          cs = 1'b0;
    logic          gwr = 1'b0;
    logic          bwe = 1'b0;
    logic [NL-1:0] bsel = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] dq_o;
    logic          dq_drive;

    always #2 clk = ~clk;

    sbsram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .dcd_mode(dcd_mode),
        .out_en(out_en), .sleep(sleep), .cs(cs), .gwr(gwr), .bwe(bwe),
        .bsel(bsel), .addr(addr), .wdata(wdata), .dq_o(dq_o), .dq_drive(dq_drive)
    );

    // Reference model state (0 deselect, 1 read, 2 write).
    logic [DW-1:0] mem_m [DEPTH];
    int            cur_op = 0;
    logic [AW-1:0] cur_addr = '0;
    logic [NL-1:0] cur_mask = '0;
    logic [DW-1:0] cur_wd = '0;
    bit            rd_prev = 1'b0;
    logic [DW-1:0] pipe_val = '0;
    int            vec = 0;
    int            bad = 0;
    bit            done = 1'b0;
    string         ptag = "R2";

    task automatic compare(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model at a rising edge, in the order the spec defines.
    task automatic model_edge();
        if (!rst_n) begin
            cur_op  = 0;
            rd_prev = 1'b0;
        end else begin
            pipe_val = mem_m[cur_addr];
            rd_prev  = (cur_op == 1);
            if (cur_op == 2) begin
                for (int l = 0; l < NL; l++) begin
                    if (cur_mask[l]) mem_m[cur_addr][l*LW +: LW] = cur_wd[l*LW +: LW];
                end
            end
            if (sleep || !cs) begin
                cur_op = 0;
            end else begin
                cur_op   = (gwr || (bwe && (|bsel))) ? 2 : 1;
                cur_addr = addr;
                cur_mask = gwr ? {NL{1'b1}} : bsel;
                cur_wd   = wdata;
            end
        end
    endtask

    // Compare the bus with the model's prediction.
    task automatic check_now();
        bit            e_drv;
        logic [DW-1:0] e_dat;
        string         dtag;
        e_drv = out_en && !sleep && rst_n &&
                (pipe_mode ? (rd_prev && (dcd_mode || cur_op != 0)) : (cur_op == 1));
        e_dat = e_drv ? (pipe_mode ? pipe_val : mem_m[cur_addr]) : '0;
        if (!rst_n)                           dtag = "R1";
        else if (sleep)                       dtag = "R10";
        else if (!out_en)                     dtag = "R9";
        else if (!pipe_mode)                  dtag = (cur_op == 0) ? "R8" : "R4";
        else if (cur_op == 0 && rd_prev)      dtag = dcd_mode ? "R6" : "R7";
        else                                  dtag = "R5";
        compare(dtag, DW'(dq_drive), DW'(e_drv));
        compare(ptag, dq_o, e_dat);
    endtask

    // Drive one command at the falling edge, clock it, check after.
    task automatic step(input bit c, input bit g, input bit b, input logic [NL-1:0] s,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        cs = c; gwr = g; bwe = b; bsel = s; addr = a; wdata = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_now();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, '0, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;

        // R1: bus quiet during and right after reset.
        ptag = "R1";
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            check_now();
        end
        rst_n = 1'b1;
        idle(2);

        // R2: global writes fill memory with stray byte controls, then read back.
        ptag = "R2";
        for (int a = 0; a < DEPTH; a++)
            step(1'b1, 1'b1, a[0], NL'(a), AW'(a), DW'({$urandom(), $urandom()}));
        for (int a = 0; a < DEPTH; a++)
            step(1'b1, 1'b0, 1'b0, '0, AW'(a), '0);
        idle(2);

        // R3: lane-selective writes, including an empty mask (a read).
        ptag = "R3";
        for (int i = 0; i < 48; i++)
            step(1'b1, 1'b0, 1'b1, NL'(i % 16), AW'(i), DW'({$urandom(), $urandom()}));
        for (int i = 0; i < 48; i++)
            step(1'b1, 1'b0, 1'b0, NL'(i), AW'(i), '0);
        idle(2);

        // R11: write then immediate read of the same word.
        ptag = "R11";
        for (int i = 0; i < 16; i++) begin
            step(1'b1, i[0], ~i[0], NL'(i + 1), AW'(100 + i), DW'({$urandom(), $urandom()}));
            step(1'b1, 1'b0, 1'b0, '0, AW'(100 + i), '0);
        end
        idle(2);

        // R4-R8: fixed patterns and random traffic in all four mode pairs.
        for (int m = 0; m < 4; m++) begin
            pipe_mode = ~m[1];
            dcd_mode  = m[0];
            ptag = pipe_mode ? "R5" : "R4";
            idle(2);
            step(1'b1, 1'b0, 1'b0, '0, 8'd3, '0);
            idle(1);
            step(1'b1, 1'b0, 1'b0, '0, 8'd4, '0);
            step(1'b1, 1'b0, 1'b0, '0, 8'd5, '0);
            idle(3);
            for (int i = 0; i < 150; i++) begin
                int k;
                k = $urandom % 10;
                step(k < 7, k == 6, k == 5, NL'($urandom), AW'($urandom % 32),
                     DW'({$urandom(), $urandom()}));
            end
            idle(3);
        end

        // R9: output enable released and restored mid-cycle.
        pipe_mode = 1'b1;
        dcd_mode  = 1'b0;
        ptag = "R9";
        step(1'b1, 1'b0, 1'b0, '0, 8'd7, '0);
        step(1'b1, 1'b0, 1'b0, '0, 8'd8, '0);
        out_en = 1'b0;
        #1;
        compare("R9", DW'(dq_drive), DW'(1'b0));
        out_en = 1'b1;
        #0.5;
        compare("R9", DW'(dq_drive), DW'(1'b1));
        compare("R9", dq_o, mem_m[7]);
        step(1'b1, 1'b0, 1'b0, '0, 8'd9, '0);

        // R10: sleep releases the bus at once and ignores writes.
        ptag = "R10";
        sleep = 1'b1;
        #1;
        compare("R10", DW'(dq_drive), DW'(1'b0));
        for (int i = 0; i < 5; i++)
            step(1'b1, 1'b1, 1'b0, '0, 8'd5, DW'(36'h123456789));
        sleep = 1'b0;
        step(1'b1, 1'b0, 1'b0, '0, 8'd5, '0);
        step(1'b1, 1'b0, 1'b0, '0, 8'd5, '0);
        idle(3);

        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        vec++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

endmodule